// File: doc/BRIEF.md
# Four-Port GPIO Register Bank

This block is a byte-wide, memory-mapped register bank for four 8-bit general-purpose I/O ports and two pin-function select registers. Each port has three registers: an output latch that holds the value to drive, a direction register that turns each pin's driver on or off, and an output-mode register that software can read and write. A fourth, read-only register per port returns the pin levels after a two-flop synchronizer. Port 3 has only two pins, so only its two low bits are implemented.

The bus is a plain single-cycle strobe interface. The host presents an address, a write or read strobe, an access size and write data. Read data and an error flag come back combinationally in the same cycle. Writes commit at the next rising clock edge. An access is rejected as a whole if any of these hold: it targets an unmapped offset, it is wider than one byte, it writes a read-only register, or it tries to set an unimplemented bit. A rejected access changes nothing and returns zero data.

Top module: `gpio_regbank`

## Requirements
- R1: Port p (0 to 3) has its registers at byte offset 4*(p/2) + (p mod 2) above four bases: output latch 0x00, mode 0x20, direction 0x60 and input 0x80. A legal read (bus_rd high, bus_wr low, bus_size 0) returns the addressed register on bus_rdata in the same cycle. A legal write updates the register at the next rising clock edge.
- R2: Function select A sits at offset 0x44 and implements bits 1:0. Function select B sits at 0x48 and implements bits 3:0. Their current values drive func_sel_a and func_sel_b.
- R3: A synchronous reset clears every register to zero, except two: the port 2 mode register resets to 0xFF and function select B resets to 0x0F.
- R4: The port 3 output, mode and direction registers implement bits 1:0 only. A write with any of bits 7:2 set raises bus_err and leaves the register unchanged.
- R5: The mode registers of ports 0 and 1 implement bit 0 only. A write with any of bits 7:1 set raises bus_err and leaves the register unchanged.
- R6: A write to a function select register that sets any bit outside its implemented field raises bus_err and leaves the register unchanged.
- R7: The input registers are read-only. A write to one raises bus_err and changes no state.
- R8: An access to any offset outside the map raises bus_err. A read there returns zero, and a write there changes no state.
- R9: A bus_size other than 0 (one byte), or bus_wr and bus_rd asserted together, raises bus_err. Such an access returns zero and changes no state.
- R10: Each input register returns the port's pins as sampled two rising edges earlier. Port 3 input bits 7:2 read as zero.
- R11: pad_oe for each pin equals its direction bit. pad_out equals the output latch bit where the direction bit is 1 and is 0 elsewhere. Byte p of each pad vector belongs to port p.
- R12: bus_err is high only in a cycle where a rejected access is presented. bus_rdata is zero whenever bus_err is high or no legal read is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size code, 0 = one byte, others illegal |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| bus_err | output | 1 | Access rejected, same cycle |
| pin_in | input | 32 | Pin levels, byte p for port p |
| pad_out | output | 32 | Pad drive value, byte p for port p |
| pad_oe | output | 32 | Pad driver enable, byte p for port p |
| func_sel_a | output | 2 | Function select A value |
| func_sel_b | output | 4 | Function select B value |

## Verification
The bench aims at the narrow registers with one reserved bit set at a time and with legal values at the edge of the field. A design that masked reserved bits instead of rejecting the write would silently change the register. A design with a logical rather than bitwise reserved-bit test would reject every non-zero write to the select registers. Offsets next to mapped ones (0x02, 0x06, 0x40, 0x45, 0x86) catch a decoder that ignores address bits, and that decoder would alias a register or fail to flag the error. Pin changes are read back on each of the following cycles to expose a synchronizer that is one stage short or one stage long, and stray upper pins on port 3 expose an input register that is not masked.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;

    localparam int NPORT  = 4;
    localparam int PW     = 8;
    localparam int AW     = 8;
    localparam int PIDX_W = $clog2(NPORT);
    localparam int SZ_W   = 2;
    localparam int SELA_W = 2;
    localparam int SELB_W = 4;

    typedef enum logic [2:0] {
        K_NONE,
        K_OUT,
        K_MODE,
        K_DIR,
        K_IN,
        K_SELA,
        K_SELB
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [PIDX_W-1:0]  port;
    } reg_sel_t;

    localparam logic [AW-1:0] SELA_ADDR = 8'h44;
    localparam logic [AW-1:0] SELB_ADDR = 8'h48;

    localparam logic [PW-1:0] FULL_MASK  = {PW{1'b1}};
    localparam logic [PW-1:0] NARROW_MSK = PW'(8'h03);
    localparam logic [PW-1:0] BIT0_MSK   = PW'(8'h01);
    localparam logic [PW-1:0] SELA_MSK   = PW'((1 << SELA_W) - 1);
    localparam logic [PW-1:0] SELB_MSK   = PW'((1 << SELB_W) - 1);
    localparam logic [PW-1:0] SELA_RST   = '0;
    localparam logic [PW-1:0] SELB_RST   = PW'(8'h0F);

    // Port index = {addr[2], addr[0]}; the 32-byte bank is picked by addr[7:5].
    function automatic reg_sel_t decode_addr(input logic [AW-1:0] a);
        reg_sel_t r;
        r.kind = K_NONE;
        r.port = {a[2], a[0]};
        if (a[4:3] == 2'b00 && a[1] == 1'b0) begin
            case (a[7:5])
                3'd0:    r.kind = K_OUT;
                3'd1:    r.kind = K_MODE;
                3'd3:    r.kind = K_DIR;
                3'd4:    r.kind = K_IN;
                default: r.kind = K_NONE;
            endcase
        end
        if (a == SELA_ADDR) r.kind = K_SELA;
        if (a == SELB_ADDR) r.kind = K_SELB;
        return r;
    endfunction

    function automatic logic [PW-1:0] write_mask(input reg_kind_e k,
                                                 input logic [PIDX_W-1:0] p);
        logic [PW-1:0] m;
        case (k)
            K_OUT, K_DIR: m = (p == 2'd3) ? NARROW_MSK : FULL_MASK;
            K_MODE: begin
                if (p == 2'd3)      m = NARROW_MSK;
                else if (p == 2'd2) m = FULL_MASK;
                else                m = BIT0_MSK;
            end
            K_SELA:  m = SELA_MSK;
            K_SELB:  m = SELB_MSK;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [PW-1:0] mode_reset(input int p);
        return (p == 2) ? FULL_MASK : '0;
    endfunction

endpackage

// File: rtl/gpio_rb_decode.sv
module gpio_rb_decode
    import gpio_rb_pkg::*;
(
    input  logic [AW-1:0]   addr,
    input  logic            wr,
    input  logic            rd,
    input  logic [SZ_W-1:0] size,
    input  logic [PW-1:0]   wdata,
    output reg_sel_t        sel,
    output logic            wr_ok,
    output logic            rd_ok,
    output logic            err
);

    logic          access;
    logic          bad_mix;
    logic          bad_size;
    logic          bad_addr;
    logic          ro_hit;
    logic          resv_hit;
    logic [PW-1:0] mask;

    always_comb begin
        sel      = decode_addr(addr);
        mask     = write_mask(sel.kind, sel.port);
        access   = wr | rd;
        bad_mix  = wr & rd;
        bad_size = (size != '0);
        bad_addr = (sel.kind == K_NONE);
        ro_hit   = wr & (sel.kind == K_IN);
        resv_hit = wr & ((wdata & ~mask) != '0);
        err      = access & (bad_mix | bad_size | bad_addr | ro_hit | resv_hit);
        wr_ok    = wr & ~rd & ~err;
        rd_ok    = rd & ~wr & ~err;
    end

endmodule

// File: rtl/gpio_rb_port.sv
module gpio_rb_port
    import gpio_rb_pkg::*;
#(
    parameter int PIDX = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_out,
    input  logic          we_mode,
    input  logic          we_dir,
    input  logic [PW-1:0] wdata,
    input  logic [PW-1:0] pins,
    output logic [PW-1:0] out_q,
    output logic [PW-1:0] mode_q,
    output logic [PW-1:0] dir_q,
    output logic [PW-1:0] in_q
);

    localparam logic [PIDX_W-1:0] PSEL     = PIDX_W'(PIDX);
    localparam logic [PW-1:0]     OUT_MSK  = write_mask(K_OUT, PSEL);
    localparam logic [PW-1:0]     MODE_MSK = write_mask(K_MODE, PSEL);
    localparam logic [PW-1:0]     DIR_MSK  = write_mask(K_DIR, PSEL);
    localparam logic [PW-1:0]     PIN_MSK  = OUT_MSK;
    localparam logic [PW-1:0]     MODE_RST = mode_reset(PIDX);

    logic [PW-1:0] sync1;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            mode_q <= MODE_RST;
            dir_q  <= '0;
        end else begin
            if (we_out)  out_q  <= wdata;
            if (we_mode) mode_q <= wdata;
            if (we_dir)  dir_q  <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= '0;
            in_q  <= '0;
        end else begin
            sync1 <= pins & PIN_MSK;
            in_q  <= sync1;
        end
    end

    // R3: reset values appear one edge after reset is seen
    a_r3_reset_values: assert property (@(posedge clk)
        rst |=> (out_q == '0 && dir_q == '0 && mode_q == MODE_RST));

    // R4 / R5: the decoder must never let a reserved bit into storage
    a_r4_r5_reserved_bits: assert property (@(posedge clk) disable iff (rst)
        ((out_q & ~OUT_MSK) == '0) && ((mode_q & ~MODE_MSK) == '0)
        && ((dir_q & ~DIR_MSK) == '0));

    // R8: without a write strobe the latch holds
    a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
        !we_out |=> $stable(out_q));

    // R10: unimplemented input bits stay zero
    a_r10_input_masked: assert property (@(posedge clk) disable iff (rst)
        (in_q & ~PIN_MSK) == '0);

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_rb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [AW-1:0]       bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [SZ_W-1:0]     bus_size,
    input  logic [PW-1:0]       bus_wdata,
    output logic [PW-1:0]       bus_rdata,
    output logic                bus_err,
    input  logic [NPORT*PW-1:0] pin_in,
    output logic [NPORT*PW-1:0] pad_out,
    output logic [NPORT*PW-1:0] pad_oe,
    output logic [SELA_W-1:0]   func_sel_a,
    output logic [SELB_W-1:0]   func_sel_b
);

    reg_sel_t sel;
    logic     wr_ok;
    logic     rd_ok;

    gpio_rb_decode u_dec (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .size  (bus_size),
        .wdata (bus_wdata),
        .sel   (sel),
        .wr_ok (wr_ok),
        .rd_ok (rd_ok),
        .err   (bus_err)
    );

    logic [PW-1:0]       out_a  [NPORT];
    logic [PW-1:0]       mode_a [NPORT];
    logic [PW-1:0]       dir_a  [NPORT];
    logic [PW-1:0]       in_a   [NPORT];
    logic [NPORT*PW-1:0] mode_v;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        logic hit;
        assign hit = wr_ok && (sel.port == PIDX_W'(g));

        gpio_rb_port #(.PIDX(g)) u_port (
            .clk     (clk),
            .rst     (rst),
            .we_out  (hit && sel.kind == K_OUT),
            .we_mode (hit && sel.kind == K_MODE),
            .we_dir  (hit && sel.kind == K_DIR),
            .wdata   (bus_wdata),
            .pins    (pin_in[g*PW +: PW]),
            .out_q   (out_a[g]),
            .mode_q  (mode_a[g]),
            .dir_q   (dir_a[g]),
            .in_q    (in_a[g])
        );

        assign pad_oe [g*PW +: PW] = dir_a[g];
        assign pad_out[g*PW +: PW] = out_a[g] & dir_a[g];
        assign mode_v [g*PW +: PW] = mode_a[g];
    end

    logic [PW-1:0] sel_a_q;
    logic [PW-1:0] sel_b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_a_q <= SELA_RST;
            sel_b_q <= SELB_RST;
        end else if (wr_ok) begin
            if (sel.kind == K_SELA) sel_a_q <= bus_wdata;
            if (sel.kind == K_SELB) sel_b_q <= bus_wdata;
        end
    end

    assign func_sel_a = sel_a_q[SELA_W-1:0];
    assign func_sel_b = sel_b_q[SELB_W-1:0];

    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            case (sel.kind)
                K_OUT:   bus_rdata = out_a[sel.port];
                K_MODE:  bus_rdata = mode_a[sel.port];
                K_DIR:   bus_rdata = dir_a[sel.port];
                K_IN:    bus_rdata = in_a[sel.port];
                K_SELA:  bus_rdata = sel_a_q;
                K_SELB:  bus_rdata = sel_b_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    // R12: a rejected access returns no data
    a_r12_err_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> bus_rdata == '0);

    // R8 / R9: a rejected access leaves every register untouched
    a_r8_err_no_update: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> ($stable(pad_out) && $stable(pad_oe) && $stable(mode_v)
                     && $stable(sel_a_q) && $stable(sel_b_q)));

    // R6: select registers never hold bits outside their fields
    a_r6_sel_reserved: assert property (@(posedge clk) disable iff (rst)
        ((sel_a_q & ~SELA_MSK) == '0) && ((sel_b_q & ~SELB_MSK) == '0));

    // R12: no error without a strobe
    a_r12_idle_no_err: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && !bus_rd) |-> !bus_err);

endmodule

// File: tb/tb_gpio_regbank.sv
module tb_gpio_regbank;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_err;
    logic [31:0] pins = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [1:0]  func_sel_a;
    logic [3:0]  func_sel_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_regbank dut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_err    (bus_err),
        .pin_in     (pins),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .func_sel_a (func_sel_a),
        .func_sel_b (func_sel_b)
    );

    // ---------------- reference model ----------------
    int m_out[4], m_mode[4], m_dir[4], m_s1[4], m_s2[4];
    int m_sa, m_sb;
    int total = 0;
    int failed = 0;
    bit started = 0;
    bit finished = 0;
    string cur_req = "R3";

    // kind: 0 none, 1 out, 2 mode, 3 dir, 4 input, 5 select A, 6 select B
    function automatic void m_decode(input int a, output int kind, output int port);
        kind = 0;
        port = 0;
        for (int p = 0; p < 4; p++) begin
            int off;
            off = (p / 2) * 4 + (p % 2);
            if (a == off)        begin kind = 1; port = p; end
            if (a == off + 32)   begin kind = 2; port = p; end
            if (a == off + 96)   begin kind = 3; port = p; end
            if (a == off + 128)  begin kind = 4; port = p; end
        end
        if (a == 68) kind = 5;
        if (a == 72) kind = 6;
    endfunction

    function automatic int m_mask(input int kind, input int port);
        if (kind == 1 || kind == 3) return (port == 3) ? 3 : 255;
        if (kind == 2) begin
            if (port == 3) return 3;
            if (port == 2) return 255;
            return 1;
        end
        if (kind == 5) return 3;
        if (kind == 6) return 15;
        return 0;
    endfunction

    function automatic int m_value(input int kind, input int port);
        case (kind)
            1: return m_out[port];
            2: return m_mode[port];
            3: return m_dir[port];
            4: return m_s2[port];
            5: return m_sa;
            6: return m_sb;
            default: return 0;
        endcase
    endfunction

    function automatic void m_eval(output int e_err, output int e_rd);
        int kind, port, wr, rd, d;
        wr = int'(bus_wr);
        rd = int'(bus_rd);
        d  = int'(bus_wdata);
        m_decode(int'(bus_addr), kind, port);
        e_err = 0;
        if (wr || rd) begin
            if (wr && rd)                          e_err = 1;
            if (bus_size != 0)                     e_err = 1;
            if (kind == 0)                         e_err = 1;
            if (wr && kind == 4)                   e_err = 1;
            if (wr && ((d & ~m_mask(kind, port)) != 0)) e_err = 1;
        end
        e_rd = (rd && !wr && !e_err) ? m_value(kind, port) : 0;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            for (int p = 0; p < 4; p++) begin
                m_out[p] = 0; m_dir[p] = 0; m_s1[p] = 0; m_s2[p] = 0;
                m_mode[p] = (p == 2) ? 255 : 0;
            end
            m_sa = 0;
            m_sb = 15;
        end else begin
            int e_err, e_rd, kind, port;
            m_eval(e_err, e_rd);
            m_decode(int'(bus_addr), kind, port);
            if (bus_wr && !e_err) begin
                case (kind)
                    1: m_out[port]  = int'(bus_wdata);
                    2: m_mode[port] = int'(bus_wdata);
                    3: m_dir[port]  = int'(bus_wdata);
                    5: m_sa         = int'(bus_wdata);
                    6: m_sb         = int'(bus_wdata);
                    default: ;
                endcase
            end
            for (int p = 0; p < 4; p++) begin
                m_s2[p] = m_s1[p];
                m_s1[p] = int'(pins[p*8 +: 8]) & ((p == 3) ? 3 : 255);
            end
        end
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    // compared every cycle, after the stimulus has settled
    always @(negedge clk) begin
        #2;
        if (started && !finished) begin
            int e_err, e_rd;
            logic [31:0] e_po, e_oe;
            m_eval(e_err, e_rd);
            for (int p = 0; p < 4; p++) begin
                e_oe[p*8 +: 8] = 8'(m_dir[p]);
                e_po[p*8 +: 8] = 8'(m_out[p] & m_dir[p]);
            end
            chk(cur_req, "bus_err (R12)", int'(bus_err), e_err);
            chk(cur_req, "bus_rdata (R12)", int'(bus_rdata), e_rd);
            chk("R11", "pad_oe", int'(pad_oe), int'(e_oe));
            chk("R11", "pad_out", int'(pad_out), int'(e_po));
            chk("R2", "func_sel_a", int'(func_sel_a), m_sa);
            chk("R2", "func_sel_b", int'(func_sel_b), m_sb);
        end
    end

    task automatic acc(input bit w, input bit r, input int sz, input int a, input int d);
        @(negedge clk);
        bus_wr    = w;
        bus_rd    = r;
        bus_size  = 2'(sz);
        bus_addr  = 8'(a);
        bus_wdata = 8'(d);
    endtask

    task automatic wr(input int a, input int d);
        acc(1, 0, 0, a, d);
    endtask

    task automatic rd(input int a);
        acc(0, 1, 0, a, 0);
    endtask

    task automatic idle();
        acc(0, 0, 0, 0, 0);
    endtask

    task automatic read_all();
        for (int p = 0; p < 4; p++) begin
            int off;
            off = (p / 2) * 4 + (p % 2);
            rd(off); rd(off + 32); rd(off + 96); rd(off + 128);
        end
        rd(68); rd(72);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        cur_req = "R3";                     // reset values
        read_all();

        cur_req = "R1";                     // legal writes across the map
        wr(0, 'hA5); wr(1, 'h3C); wr(4, 'hF0);
        wr(96, 'hFF); wr(97, 'h0F); wr(100, 'h55);
        wr(36, 'h5A); wr(32, 'h01); wr(33, 'h01);
        read_all();
        idle();

        cur_req = "R4";                     // port 3 narrow registers
        wr(5, 'h03); wr(101, 'h01); wr(37, 'h02);
        wr(5, 'h04); wr(101, 'h80); wr(37, 'hFF);
        rd(5); rd(101); rd(37);

        cur_req = "R5";                     // port 0/1 mode registers
        wr(32, 'h02); wr(33, 'h80); wr(32, 'h00);
        rd(32); rd(33);

        cur_req = "R6";                     // select fields
        wr(68, 'h03); wr(68, 'h04); wr(72, 'h0A); wr(72, 'h10); wr(72, 'h00);
        rd(68); rd(72);

        cur_req = "R7";                     // input registers read-only
        pins = 32'h1234_5678;
        wr(128, 'hFF); wr(133, 'h01);
        rd(128); rd(129); rd(132); rd(133);

        cur_req = "R8";                     // unmapped offsets
        rd(2); rd(3); rd(6); rd(64); rd(69); rd(134); rd(255);
        wr(2, 'h11); wr(6, 'h22); wr(64, 'h01); wr(69, 'h01); wr(255, 'h00);
        rd(0);

        cur_req = "R9";                     // size and strobe conflicts
        acc(1, 0, 1, 0, 'h00); acc(1, 0, 2, 96, 'h00); acc(0, 1, 3, 0, 0);
        acc(1, 1, 0, 0, 'h00); rd(0); rd(96);

        cur_req = "R10";                    // synchronizer depth and port 3 mask
        @(negedge clk); bus_wr = 0; bus_rd = 1; bus_size = 0; bus_addr = 8'd133;
        pins = 32'hFFAA_55C3;
        repeat (4) @(negedge clk);
        bus_addr = 8'd128;
        pins = 32'h0F00_0081;
        repeat (4) @(negedge clk);

        cur_req = "R11";                    // pads follow direction
        wr(96, 'h00); wr(0, 'hFF); wr(97, 'hFF); wr(101, 'h03); wr(5, 'h02);

        cur_req = "R12";                    // idle bus
        idle(); idle();

        cur_req = "R3";                     // reset again mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        read_all();
        idle();
        @(negedge clk);
        finish_run();
    end

endmodule